// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

The block is a watchdog timer with a small register bus. Software enables it and then has to kick it at regular intervals. The count runs on a slow tick, derived from the input clock by a counter of 2^TICK_EXP cycles. A two-bit scale field stretches that tick by 1, 2, 4 or 8.

If no kick arrives, the first phase runs out. This latches a pretimeout status bit and raises the interrupt line. From that point on the timer can no longer be switched off. A second phase then starts. If it also runs out without a kick, the block sends a one-cycle request on one of three reset outputs, chosen by a mode field. The reset distribution, the clock source and any bus bridge sit outside the block.

There are three 32-bit registers at byte offsets 0x0, 0x4 and 0x8:

- **Kick (0x0):** writing 1 to bit 31 kicks the timer.
- **Status (0x4):** bit 31 is the phase-one flag and bit 30 is the phase-two flag. Each flag is sticky and is cleared by writing 1 to it.
- **Config (0x8):** holds the following fields.
  - bit 31: enable
  - bits 30:29: tick scale
  - bits 26:22: phase-one limit
  - bits 19:15: phase-two limit
  - bits 1:0: reset mode

A read returns the selected register combinationally in the same cycle.

Top module: `wdog_twophase`

## Requirements
- R1: After reset the config register reads 0x0000_0001 (enable 0, mode 1). The status and kick registers read 0. The interrupt and all three reset request outputs are low.
- R2: One tick lasts 2^(TICK_EXP + S) clock cycles, where S is config bits 30:29.
- R3: Phase one runs (L1+1) ticks, counted from the write that sets enable (config bit 31) or from the last kick. L1 is config bits 26:22. When it expires, status bit 31 is set and the interrupt output goes high.
- R4: Phase two starts when phase one expires and runs (L2+1) ticks. L2 is config bits 19:15. When it expires, status bit 30 is set and one reset request output is high for exactly one cycle.
- R5: The reset request output is chosen by config bits 1:0. Mode 0 selects the chip reset, mode 1 the processor reset, mode 2 the software reset, and mode 3 the chip reset. No more than one request is ever high.
- R6: A write to offset 0x0 with bit 31 set is a kick. A kick restarts phase one with a cleared tick prescaler, and it also works during phase two. A write to 0x0 with bit 31 clear has no effect.
- R7: Writing 1 to status bit 31 or bit 30 clears that bit, and writing 0 leaves it unchanged. The interrupt follows status bit 31 and stays high until that bit is cleared.
- R8: Once phase one has expired, writing 0 to the enable bit is ignored. The enable bit still reads 1 and the reset request still follows. Only the reset input clears this lock.
- R9: If enable is cleared before phase one expires, counting stops and all progress, including the prescaler, is discarded. No interrupt follows, and a later enable starts a full phase one.
- R10: Register bits that hold no field read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_pretimeout | output | 1 | Phase-one interrupt, level |
| rst_req_chip | output | 1 | Full chip reset request pulse |
| rst_req_cpu | output | 1 | Processor reset request pulse |
| rst_req_sw | output | 1 | Software reset request pulse |

## Verification
The hardest state to reach from the ports is a kick or a disable write that lands after phase one has expired. This is where the lock and the phase restart interact. The bench shrinks the base tick to four cycles, sets a long phase-one limit and counts cycles from each write. This lets it place the disable write in the gap between the interrupt and the reset pulse, and a kick partway into phase two. A sweep over every tick scale, with short, middle and maximal limits, times both expiries against (L+1)·2^(TICK_EXP+S) in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] pscale;
    logic [4:0] lim1;
    logic [4:0] lim2;
    logic [1:0] mode;
  } wd_cfg_t;

  typedef enum logic [1:0] {
    RM_CHIP = 2'd0,
    RM_CPU  = 2'd1,
    RM_SOFT = 2'd2,
    RM_ALT  = 2'd3
  } rmode_e;

  // Register image of the config fields; all other bits are zero.
  function automatic logic [31:0] pack_cfg(wd_cfg_t c);
    return {c.en, c.pscale, 2'b00, c.lim1, 2'b00, c.lim2, 13'd0, c.mode};
  endfunction

  function automatic wd_cfg_t unpack_cfg(logic [31:0] d);
    wd_cfg_t c;
    c.en     = d[31];
    c.pscale = d[30:29];
    c.lim1   = d[26:22];
    c.lim2   = d[19:15];
    c.mode   = d[1:0];
    return c;
  endfunction

  // Last prescaler count value of one tick: 2^(exp+ps) - 1.
  function automatic logic [31:0] tick_last(int unsigned e, logic [1:0] ps);
    return (32'd1 << (e + 32'(ps))) - 32'd1;
  endfunction

  // Request vector {chip, cpu, sw} for a mode value.
  function automatic logic [2:0] rst_select(logic [1:0] m);
    case (rmode_e'(m))
      RM_CPU:  return 3'b010;
      RM_SOFT: return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned TICK_EXP = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] pscale,
  output logic       tick
);
  import wdog_pkg::*;

  localparam int unsigned CW = TICK_EXP + 3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = CW'(tick_last(TICK_EXP, pscale));
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clear)  cnt <= '0;
    else if (tick)           cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_phase_seq.sv
module wdog_phase_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       kick,
  input  logic       tick,
  input  logic [4:0] lim1,
  input  logic [4:0] lim2,
  output logic       ph1_fire,
  output logic       ph2_fire
);
  logic       in_ph2;
  logic [4:0] nticks;
  logic       at_lim;
  logic       step;

  assign at_lim   = nticks == (in_ph2 ? lim2 : lim1);
  assign step     = run && !kick && tick;
  assign ph1_fire = step && at_lim && !in_ph2;
  assign ph2_fire = step && at_lim && in_ph2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ph2 <= 1'b0;
      nticks <= '0;
    end else if (!run || kick) begin
      in_ph2 <= 1'b0;
      nticks <= '0;
    end else if (tick) begin
      if (at_lim) begin
        in_ph2 <= !in_ph2;
        nticks <= '0;
      end else begin
        nticks <= nticks + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              ph1_fire,
  input  logic              ph2_fire,
  output logic [31:0]       rdata,
  output wdog_pkg::wd_cfg_t cfg,
  output logic              kick,
  output logic              locked,
  output logic              irq
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] OFS_KICK = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h8);
  localparam logic              IRQ_EN   = 1'b1;

  logic    st1, st2;
  logic    wr_cfg, wr_stat;
  wd_cfg_t wcfg;

  assign wr_cfg  = we && (addr == OFS_CFG);
  assign wr_stat = we && (addr == OFS_STAT);
  assign kick    = we && (addr == OFS_KICK) && wdata[31];
  assign wcfg    = unpack_cfg(wdata);
  assign irq     = st1 & IRQ_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{en: 1'b0, pscale: 2'd0, lim1: 5'd0, lim2: 5'd0, mode: RM_CPU};
      locked <= 1'b0;
    end else begin
      if (ph1_fire) locked <= 1'b1;
      if (wr_cfg) begin
        cfg    <= wcfg;
        cfg.en <= wcfg.en | locked | ph1_fire;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 1'b0;
      st2 <= 1'b0;
    end else begin
      if (ph1_fire)                   st1 <= 1'b1;
      else if (wr_stat && wdata[31])  st1 <= 1'b0;
      if (ph2_fire)                   st2 <= 1'b1;
      else if (wr_stat && wdata[30])  st2 <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_STAT)     rdata = {st1, st2, 30'd0};
    else if (addr == OFS_CFG) rdata = pack_cfg(cfg);
  end

  // R8
  lock_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> cfg.en);

  // R7
  sticky_st1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st1 && !(wr_stat && wdata[31])) |=> st1);

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] mode,
  output logic       req_chip,
  output logic       req_cpu,
  output logic       req_sw
);
  import wdog_pkg::*;

  logic [2:0] req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    req <= '0;
    else if (fire) req <= rst_select(mode);
    else           req <= '0;
  end

  assign {req_chip, req_cpu, req_sw} = req;

endmodule

// File: rtl/wdog_twophase.sv
module wdog_twophase #(
  parameter int unsigned TICK_EXP = 25,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pretimeout,
  output logic              rst_req_chip,
  output logic              rst_req_cpu,
  output logic              rst_req_sw
);
  import wdog_pkg::*;

  wd_cfg_t cfg;
  logic    kick, locked, tick, ph1_fire, ph2_fire;
  logic    any_req;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .ph1_fire(ph1_fire), .ph2_fire(ph2_fire), .rdata(bus_rdata), .cfg(cfg),
    .kick(kick), .locked(locked), .irq(irq_pretimeout)
  );

  wdog_tick_gen #(.TICK_EXP(TICK_EXP)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(cfg.en), .clear(kick),
    .pscale(cfg.pscale), .tick(tick)
  );

  wdog_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(cfg.en), .kick(kick), .tick(tick),
    .lim1(cfg.lim1), .lim2(cfg.lim2), .ph1_fire(ph1_fire), .ph2_fire(ph2_fire)
  );

  wdog_rst_gen u_rst (
    .clk(clk), .rst_n(rst_n), .fire(ph2_fire), .mode(cfg.mode),
    .req_chip(rst_req_chip), .req_cpu(rst_req_cpu), .req_sw(rst_req_sw)
  );

  assign any_req = rst_req_chip | rst_req_cpu | rst_req_sw;

  // R5
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_chip, rst_req_cpu, rst_req_sw}));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  // R4
  ph2_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_fire |=> (any_req && bus_rdata[30] == (bus_addr == ADDR_W'(4'h4)) | bus_rdata[30]));

  // R3
  ph1_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_fire |=> irq_pretimeout);

  // R8
  lock_after_ph1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_fire |=> locked);

endmodule

// File: tb/wdog_twophase_tb.sv
module wdog_twophase_tb;

  localparam int unsigned TE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rc, rp, rs;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdog_twophase #(.TICK_EXP(TE), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_pretimeout(irq),
    .rst_req_chip(rc), .rst_req_cpu(rp), .rst_req_sw(rs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input logic en, input int ps, input int l1,
                                       input int l2, input int md);
    return {en, 2'(ps), 2'b00, 5'(l1), 2'b00, 5'(l2), 13'd0, 2'(md)};
  endfunction

  function automatic logic [2:0] exp_vec(input int md);
    if (md == 1) return 3'b010;
    if (md == 2) return 3'b001;
    return 3'b100;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  // Cycle numbers are counted in rising edges after the last call point.
  task automatic obs(input int maxc, output int t_irq, output int t_rst,
                     output logic [2:0] vec, output int width);
    t_irq = -1; t_rst = -1; vec = '0; width = 0;
    for (int c = 1; c <= maxc; c++) begin
      @(posedge clk);
      #1;
      if (irq && t_irq < 0) t_irq = c;
      if (rc | rp | rs) begin
        if (t_rst < 0) begin
          t_rst = c;
          vec = {rc, rp, rs};
        end
        width++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  v;
    int ti, tr, w, idx;
    int l1s[3] = '{0, 3, 31};
    int l2s[3] = '{0, 5, 31};

    do_reset();
    // R1 reset state
    rd(4'h8, d); chk("R1 config", d, 32'h0000_0001);
    rd(4'h4, d); chk("R1 status", d, 32'h0);
    rd(4'h0, d); chk("R1 kick reg", d, 32'h0);
    chk("R1 outputs", {28'd0, irq, rc, rp, rs}, 32'h0);

    // R10 unused bits
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R10 config mask", d, 32'hE7CF_8003);
    rd(4'h0, d); chk("R10 kick reads zero", d, 32'h0);

    // R2 R3 R4 R5 sweep over scale and limits
    idx = 0;
    for (int ps = 0; ps < 4; ps++) begin
      for (int i = 0; i < 3; i++) begin
        for (int j = 0; j < 3; j++) begin
          int lt, e1, e2, md;
          md = idx % 4;
          idx++;
          lt = (1 << TE) << ps;
          e1 = (l1s[i] + 1) * lt;
          e2 = (l1s[i] + l2s[j] + 2) * lt;
          do_reset();
          wr(4'h8, cfgw(1'b1, ps, l1s[i], l2s[j], md));
          obs(e2 + 3, ti, tr, v, w);
          chk("R2 R3 phase1 time", ti, e1);
          chk("R4 phase2 time", tr, e2);
          chk("R4 pulse width", w, 1);
          chk("R5 mode select", {29'd0, v}, {29'd0, exp_vec(md)});
        end
      end
    end

    // R6 non-kick write ignored: expiry stays at 16 from enable
    do_reset();
    wr(4'h8, cfgw(1'b1, 0, 3, 2, 1));
    idle(5);
    wr(4'h0, 32'h7FFF_FFFF);
    obs(12, ti, tr, v, w);
    chk("R6 write without bit31 no effect", ti, 10);

    // R6 kick in phase one restarts the count
    do_reset();
    wr(4'h8, cfgw(1'b1, 0, 3, 2, 1));
    idle(9);
    wr(4'h0, 32'h8000_0000);
    obs(31, ti, tr, v, w);
    chk("R6 kick phase1 irq", ti, 16);
    chk("R6 kick phase1 reset", tr, 28);

    // R6 kick during phase two
    do_reset();
    wr(4'h8, cfgw(1'b1, 0, 1, 3, 0));
    obs(12, ti, tr, v, w);
    chk("R6 pre-kick irq", ti, 8);
    chk("R6 no reset before kick", tr, -1);
    wr(4'h0, 32'h8000_0000);
    obs(30, ti, tr, v, w);
    chk("R6 kick in phase2 reset time", tr, 24);
    chk("R7 irq held until cleared", ti, 1);
    chk("R5 chip select", {29'd0, v}, 32'd4);

    // R9 disable before phase one expiry
    do_reset();
    wr(4'h8, cfgw(1'b1, 0, 1, 0, 1));
    idle(4);
    wr(4'h8, cfgw(1'b0, 0, 1, 0, 1));
    idle(20);
    chk("R9 no irq after disable", {31'd0, irq}, 32'd0);
    wr(4'h8, cfgw(1'b1, 0, 1, 0, 1));
    obs(12, ti, tr, v, w);
    chk("R9 fresh phase1 after re-enable", ti, 8);

    // R8 lock and R7 clearing
    do_reset();
    wr(4'h8, cfgw(1'b1, 0, 31, 0, 2));
    obs(130, ti, tr, v, w);
    chk("R3 long phase1", ti, 128);
    wr(4'h8, cfgw(1'b0, 0, 31, 0, 2));
    rd(4'h8, d);
    chk("R8 enable locked", d, cfgw(1'b1, 0, 31, 0, 2));
    obs(5, ti, tr, v, w);
    chk("R8 reset still follows", tr, 1);
    chk("R5 software select", {29'd0, v}, 32'd1);
    rd(4'h4, d); chk("R4 both flags", d, 32'hC000_0000);
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, d); chk("R7 clear phase2 flag", d, 32'h8000_0000);
    chk("R7 irq still high", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R7 write zero keeps", d, 32'h8000_0000);
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, d); chk("R7 clear phase1 flag", d, 32'h0);
    chk("R7 irq low after clear", {31'd0, irq}, 32'd0);
    do_reset();
    rd(4'h8, d); chk("R8 reset releases lock", d, 32'h0000_0001);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule